// File: doc/BRIEF.md
# Speculative Two-Stage Switch Allocator

This block decides, every clock cycle, which input virtual channel (VC) of a router may drive each crossbar output. It is meant for a router that runs VC allocation and switch allocation side by side. Two allocators of the same shape work in parallel. One takes requests from packets that already own an output VC. The other takes requests from header flits that are still waiting for their VC to be assigned. Each allocator has two stages. In the first stage, one round-robin arbiter per input port picks a single VC. In the second stage, one round-robin arbiter per output port picks among the input ports that target it.

A grant from an owned VC always takes precedence over a speculative grant. A speculative grant survives only on an output that received no owned-VC grant, and only for an input port that received no owned-VC grant. Within the same cycle, a speculative grant is checked against the result of VC allocation and the on/off readiness of the newly allocated output VC. If the check fails, the grant is cancelled. A cancelled grant drives no crossbar select and moves no arbiter priority. All outputs are combinational functions of the inputs and the arbiter priority registers.

Top module: `sa_spec_alloc`

## Requirements
- R1: An input VC raises an owned-VC request only when `vc_flit`, `vc_owned` and `out_rdy[port*NV+ovc]` are all 1, where port and ovc are its `vc_port` and `vc_ovc` fields. Any other VC gets no owned-VC grant.
- R2: An input VC raises a speculative request only when `vc_flit` and `vc_head` are 1 and `vc_owned` is 0. A flit that is not a header and does not own a VC gets no grant.
- R3: Each input port receives at most one grant per cycle. When both allocators would grant the same input port, the owned-VC grant wins and the speculative one is dropped.
- R4: Each first-stage arbiter picks among the VCs of its port in round-robin order. The search starts at the VC after the last one granted and wraps around.
- R5: Each second-stage arbiter picks among the requesting input ports in round-robin order. The search starts at the port after the last one granted on that output and wraps around.
- R6: A first-stage arbiter moves its priority only when its winner also receives the final grant. A VC that loses in the second stage keeps first priority for the next cycle.
- R7: A speculative grant is given on an output port only when that port has no owned-VC grant in the same cycle.
- R8: A speculative grant is confirmed only when `vca_ok` is 1 for that VC and `out_rdy[port*NV+vca_vc]` is 1. Otherwise `spec_cancel` is set for the input port. A cancelled grant produces no crossbar select and no VC grant, and it leaves every arbiter priority unchanged.
- R9: For each output o, `xb_sel[o*NP+i]` is one-hot on the chosen input i, and `xb_vld[o]` is set exactly when a select is set. `in_gnt_vc` carries the granted VC index of each input port, and is 0 when that port has no grant. `vc_gnt[i*NV+v]` marks the granted VC. `in_gnt_spec` marks confirmed speculative grants.
- R10: After reset, every arbiter gives first priority to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vc_flit | input | NP*NV | Input VC holds a flit (index i*NV+v) |
| vc_head | input | NP*NV | Flit at the head of the VC is a header |
| vc_owned | input | NP*NV | Packet already owns an output VC |
| vc_port | input | NP*NV*PW | Output port wanted by each VC |
| vc_ovc | input | NP*NV*VW | Output VC owned by each VC |
| out_rdy | input | NP*NV | On/off ready bit per output VC (index port*NV+vc) |
| vca_ok | input | NP*NV | VC allocation succeeded this cycle for this VC |
| vca_vc | input | NP*NV*VW | Output VC given by VC allocation |
| xb_sel | output | NP*NP | Per output, one-hot input-port select (index o*NP+i) |
| xb_vld | output | NP | Output port has a valid select |
| in_gnt | output | NP | Input port granted (after cancels) |
| in_gnt_vc | output | NP*VW | Granted VC index per input port |
| in_gnt_spec | output | NP | Grant came from the speculative path |
| spec_cancel | output | NP | Speculative grant withdrawn for this input port |
| vc_gnt | output | NP*NV | Per input VC final grant |

## Verification
On every cycle, the assertions check the structural rules. Each crossbar output is one-hot and agrees with its valid bit. No input port is selected twice. Every granted VC actually met the request condition of its class. A cancelled port drives nothing. A first-stage priority register stays put whenever its port was not finally granted. Round-robin order across consecutive cycles, the precedence of owned-VC traffic over speculation on a shared output or input port, and the claim that a cancel leaves fairness untouched can only be shown by the bench. It does this with directed scenarios and a table of mixed request patterns, compared against its own model of the priority registers.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // width of an index into n items, never zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb
  import sa_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr;
  logic [IW:0]   pk;

  // first request at or after p, wrapping; MSB flags a hit
  function automatic logic [IW:0] pick(input logic [N-1:0] r, input logic [IW-1:0] p);
    logic [IW:0] res;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = int'(p) + k;
      if (j >= N) j = j - N;
      if (r[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  assign pk      = pick(req, ptr);
  assign any     = pk[IW];
  assign gnt_idx = pk[IW-1:0];
  assign ptr_o   = ptr;

  always_comb begin
    gnt = '0;
    if (any) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (adv && any) ptr <= (int'(gnt_idx) == N - 1) ? '0 : IW'(gnt_idx + 1'b1);
  end
endmodule

// File: rtl/sa_class_alloc.sv
module sa_class_alloc
  import sa_pkg::*;
#(
  parameter int NP = 5,
  parameter int NV = 2,
  localparam int NI = NP * NV,
  localparam int PW = idx_w(NP),
  localparam int VW = idx_w(NV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    req,
  input  logic [NI*PW-1:0] vc_port,
  input  logic [NP-1:0]    adv1,
  input  logic [NP-1:0]    adv2,
  output logic [NP-1:0]    s1_any,
  output logic [NP*VW-1:0] s1_vc,
  output logic [NP*PW-1:0] s1_port,
  output logic [NP*NP-1:0] s2_gnt,
  output logic [NP-1:0]    s2_any,
  output logic [NP*VW-1:0] p1_ptr
);
  // stage one: one VC per input port
  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [NV-1:0] g1;
    sa_rr_arb #(.N(NV)) u_s1 (
      .clk(clk), .rst_n(rst_n), .req(req[i*NV +: NV]), .adv(adv1[i]),
      .gnt(g1), .gnt_idx(s1_vc[i*VW +: VW]), .any(s1_any[i]),
      .ptr_o(p1_ptr[i*VW +: VW])
    );
    assign s1_port[i*PW +: PW] = vc_port[(i*NV + int'(s1_vc[i*VW +: VW]))*PW +: PW];
  end

  // stage two: one input port per output port
  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [NP-1:0] r2;
    logic [PW-1:0] w2;
    logic [PW-1:0] p2;
    always_comb begin
      for (int i = 0; i < NP; i++)
        r2[i] = s1_any[i] && (int'(s1_port[i*PW +: PW]) == o);
    end
    sa_rr_arb #(.N(NP)) u_s2 (
      .clk(clk), .rst_n(rst_n), .req(r2), .adv(adv2[o]),
      .gnt(s2_gnt[o*NP +: NP]), .gnt_idx(w2), .any(s2_any[o]), .ptr_o(p2)
    );
  end
endmodule

// File: rtl/sa_spec_alloc.sv
module sa_spec_alloc
  import sa_pkg::*;
#(
  parameter int NP = 5,
  parameter int NV = 2,
  localparam int NI = NP * NV,
  localparam int PW = idx_w(NP),
  localparam int VW = idx_w(NV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    vc_flit,
  input  logic [NI-1:0]    vc_head,
  input  logic [NI-1:0]    vc_owned,
  input  logic [NI*PW-1:0] vc_port,
  input  logic [NI*VW-1:0] vc_ovc,
  input  logic [NI-1:0]    out_rdy,
  input  logic [NI-1:0]    vca_ok,
  input  logic [NI*VW-1:0] vca_vc,
  output logic [NP*NP-1:0] xb_sel,
  output logic [NP-1:0]    xb_vld,
  output logic [NP-1:0]    in_gnt,
  output logic [NP*VW-1:0] in_gnt_vc,
  output logic [NP-1:0]    in_gnt_spec,
  output logic [NP-1:0]    spec_cancel,
  output logic [NI-1:0]    vc_gnt
);
  logic [NI-1:0]    ns_req, sp_req;
  logic [NP-1:0]    ns_any1, sp_any1, ns_any2, sp_any2;
  logic [NP*VW-1:0] ns_vc1, sp_vc1;
  logic [NP*PW-1:0] ns_port1, sp_port1;
  logic [NP*NP-1:0] ns_g2, sp_g2, sp_pass;
  logic [NP-1:0]    ns_adv1, ns_adv2, sp_adv1, sp_adv2;
  // named internal events for the checker
  logic [NP*VW-1:0] ns1_ptr, sp1_ptr;
  logic [NP-1:0]    ns_in_hit, sp_in_hit, sp_ok, spec_keep;

  function automatic logic rdy_at(input logic [NI-1:0] rdy, input int p, input int v);
    return (p < NP) ? rdy[p*NV + v] : 1'b0;
  endfunction

  always_comb begin
    for (int k = 0; k < NI; k++) begin
      ns_req[k] = vc_flit[k] & vc_owned[k] &
                  rdy_at(out_rdy, int'(vc_port[k*PW +: PW]), int'(vc_ovc[k*VW +: VW]));
      sp_req[k] = vc_flit[k] & vc_head[k] & ~vc_owned[k];
    end
  end

  sa_class_alloc #(.NP(NP), .NV(NV)) u_ns (
    .clk(clk), .rst_n(rst_n), .req(ns_req), .vc_port(vc_port),
    .adv1(ns_adv1), .adv2(ns_adv2), .s1_any(ns_any1), .s1_vc(ns_vc1),
    .s1_port(ns_port1), .s2_gnt(ns_g2), .s2_any(ns_any2), .p1_ptr(ns1_ptr)
  );

  sa_class_alloc #(.NP(NP), .NV(NV)) u_sp (
    .clk(clk), .rst_n(rst_n), .req(sp_req), .vc_port(vc_port),
    .adv1(sp_adv1), .adv2(sp_adv2), .s1_any(sp_any1), .s1_vc(sp_vc1),
    .s1_port(sp_port1), .s2_gnt(sp_g2), .s2_any(sp_any2), .p1_ptr(sp1_ptr)
  );

  always_comb begin
    ns_in_hit = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        if (ns_g2[o*NP + i]) ns_in_hit[i] = 1'b1;

    // speculation only on outputs and inputs left free by owned traffic
    sp_in_hit = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++) begin
        sp_pass[o*NP + i] = sp_g2[o*NP + i] & ~ns_any2[o] & ~ns_in_hit[i];
        if (sp_pass[o*NP + i]) sp_in_hit[i] = 1'b1;
      end

    // same-cycle confirmation of VC allocation and buffer space
    for (int i = 0; i < NP; i++) begin
      int k;
      k = i*NV + int'(sp_vc1[i*VW +: VW]);
      sp_ok[i] = vca_ok[k] & rdy_at(out_rdy, int'(vc_port[k*PW +: PW]), int'(vca_vc[k*VW +: VW]));
    end
    spec_keep   = sp_in_hit & sp_ok;
    spec_cancel = sp_in_hit & ~sp_ok;

    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++)
        xb_sel[o*NP + i] = ns_g2[o*NP + i] | (sp_pass[o*NP + i] & sp_ok[i]);
      xb_vld[o]  = |xb_sel[o*NP +: NP];
      ns_adv2[o] = ns_any2[o];
      sp_adv2[o] = |(sp_pass[o*NP +: NP] & sp_ok);
    end

    vc_gnt = '0;
    for (int i = 0; i < NP; i++) begin
      in_gnt[i]      = ns_in_hit[i] | spec_keep[i];
      in_gnt_spec[i] = spec_keep[i];
      in_gnt_vc[i*VW +: VW] = ns_in_hit[i] ? ns_vc1[i*VW +: VW] :
                              spec_keep[i] ? sp_vc1[i*VW +: VW] : '0;
      if (in_gnt[i]) vc_gnt[i*NV + int'(in_gnt_vc[i*VW +: VW])] = 1'b1;
      ns_adv1[i] = ns_in_hit[i];
      sp_adv1[i] = spec_keep[i];
    end
  end
endmodule

// File: rtl/sa_spec_alloc_chk.sv
module sa_spec_alloc_chk
  import sa_pkg::*;
#(
  parameter int NP = 5,
  parameter int NV = 2,
  localparam int NI = NP * NV,
  localparam int PW = idx_w(NP),
  localparam int VW = idx_w(NV)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NI-1:0]    vc_flit,
  input logic [NI-1:0]    vc_head,
  input logic [NI-1:0]    vc_owned,
  input logic [NI*PW-1:0] vc_port,
  input logic [NI*VW-1:0] vc_ovc,
  input logic [NI-1:0]    out_rdy,
  input logic [NI-1:0]    vca_ok,
  input logic [NP*NP-1:0] xb_sel,
  input logic [NP-1:0]    xb_vld,
  input logic [NP-1:0]    spec_cancel,
  input logic [NI-1:0]    vc_gnt,
  input logic [NP*VW-1:0] ns1_ptr,
  input logic [NP*VW-1:0] sp1_ptr,
  input logic [NP-1:0]    ns_in_hit,
  input logic [NP-1:0]    spec_keep
);
  for (genvar o = 0; o < NP; o++) begin : g_o
    a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      xb_vld[o] |-> $onehot(xb_sel[o*NP +: NP]));
    a_r9_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xb_vld[o] |-> (xb_sel[o*NP +: NP] == '0));
  end

  for (genvar i = 0; i < NP; i++) begin : g_i
    logic [NP-1:0] col;
    always_comb
      for (int o = 0; o < NP; o++) col[o] = xb_sel[o*NP + i];
    a_r3_one_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1);
    a_r8_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      spec_cancel[i] |-> (col == '0) && (vc_gnt[i*NV +: NV] == '0));
    a_r6_ns_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ns_in_hit[i] |=> $stable(ns1_ptr[i*VW +: VW]));
    a_r8_sp_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !spec_keep[i] |=> $stable(sp1_ptr[i*VW +: VW]));
  end

  for (genvar k = 0; k < NI; k++) begin : g_k
    a_r1_owned_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_gnt[k] && vc_owned[k]) |->
        (vc_flit[k] && out_rdy[int'(vc_port[k*PW +: PW])*NV + int'(vc_ovc[k*VW +: VW])]));
    a_r2_spec_source: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_gnt[k] && !vc_owned[k]) |-> (vc_flit[k] && vc_head[k] && vca_ok[k]));
  end
endmodule

bind sa_spec_alloc sa_spec_alloc_chk #(.NP(NP), .NV(NV)) u_chk (.*);

// File: tb/sim_sa_spec_alloc.sv
module sim_sa_spec_alloc;
  localparam int NP = 5, NV = 2, NI = NP * NV, PW = 3, VW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] vc_flit, vc_head, vc_owned, out_rdy, vca_ok;
  logic [NI*PW-1:0] vc_port;
  logic [NI*VW-1:0] vc_ovc, vca_vc;
  logic [NP*NP-1:0] xb_sel;
  logic [NP-1:0] xb_vld, in_gnt, in_gnt_spec, spec_cancel;
  logic [NP*VW-1:0] in_gnt_vc;
  logic [NI-1:0] vc_gnt;

  int total = 0, bad = 0;
  bit done = 0;

  sa_spec_alloc #(.NP(NP), .NV(NV)) u0 (.*);

  always #5 clk = ~clk;

  // mixed stimulus table; vc_port holds one octal digit per VC, VC9 leftmost
  localparam int NT = 8;
  localparam logic [NI-1:0] T_FLIT [NT] = '{10'h3FF, 10'h155, 10'h2AA, 10'h0F3, 10'h3C1, 10'h1FF, 10'h333, 10'h3FF};
  localparam logic [NI-1:0] T_HEAD [NT] = '{10'h0F0, 10'h3FF, 10'h2AA, 10'h0FF, 10'h300, 10'h055, 10'h111, 10'h3FF};
  localparam logic [NI-1:0] T_OWN  [NT] = '{10'h30F, 10'h044, 10'h000, 10'h0C3, 10'h0C1, 10'h1AA, 10'h222, 10'h155};
  localparam logic [NI*PW-1:0] T_PORT [NT] = '{30'o0123401234, 30'o1111122222, 30'o3333333333,
    30'o4321043210, 30'o0000011111, 30'o2413024130, 30'o4444400000, 30'o1212121212};
  localparam logic [NI-1:0] T_OVC  [NT] = '{10'h0AA, 10'h155, 10'h000, 10'h3FF, 10'h0F0, 10'h123, 10'h321, 10'h2AA};
  localparam logic [NI-1:0] T_RDY  [NT] = '{10'h3FF, 10'h2F7, 10'h155, 10'h3FF, 10'h0FF, 10'h3AF, 10'h1FF, 10'h37E};
  localparam logic [NI-1:0] T_VOK  [NT] = '{10'h3FF, 10'h0FF, 10'h3F0, 10'h155, 10'h3FF, 10'h000, 10'h2AA, 10'h3CF};
  localparam logic [NI-1:0] T_VVC  [NT] = '{10'h000, 10'h3FF, 10'h0AA, 10'h155, 10'h321, 10'h0F0, 10'h3FF, 10'h111};

  // bench's own view of the arbiter priorities
  int n1p[NP], n2p[NP], s1p[NP], s2p[NP];
  int w_n1[NP], w_s1[NP], w_no[NP], w_so[NP];
  bit e_nshit[NP], e_keep[NP];
  logic [NP*NP-1:0] e_sel;
  logic [NP-1:0] e_vld, e_gnt, e_spec, e_cancel;
  logic [NP*VW-1:0] e_vc;
  logic [NI-1:0] e_vcg;

  function automatic int first_from(input bit [15:0] r, input int n, input int p);
    for (int k = 0; k < n; k++) if (r[(p + k) % n]) return (p + k) % n;
    return -1;
  endfunction

  function automatic int prt(input int k);
    return int'(vc_port[k*PW +: PW]);
  endfunction

  task automatic model_eval();
    e_sel = '0; e_vld = '0; e_gnt = '0; e_spec = '0; e_cancel = '0; e_vc = '0; e_vcg = '0;
    for (int i = 0; i < NP; i++) begin
      bit [15:0] rn, rs;
      rn = '0; rs = '0;
      for (int v = 0; v < NV; v++) begin
        int k;
        k = i*NV + v;
        rn[v] = vc_flit[k] && vc_owned[k] && out_rdy[prt(k)*NV + int'(vc_ovc[k])];
        rs[v] = vc_flit[k] && vc_head[k] && !vc_owned[k];
      end
      w_n1[i] = first_from(rn, NV, n1p[i]);
      w_s1[i] = first_from(rs, NV, s1p[i]);
      e_nshit[i] = 0; e_keep[i] = 0;
    end
    for (int o = 0; o < NP; o++) begin
      bit [15:0] rn, rs;
      rn = '0; rs = '0;
      for (int i = 0; i < NP; i++) begin
        rn[i] = (w_n1[i] >= 0) && (prt(i*NV + w_n1[i]) == o);
        rs[i] = (w_s1[i] >= 0) && (prt(i*NV + w_s1[i]) == o);
      end
      w_no[o] = first_from(rn, NP, n2p[o]);
      w_so[o] = first_from(rs, NP, s2p[o]);
      if (w_no[o] >= 0) begin
        e_nshit[w_no[o]] = 1;
        e_sel[o*NP + w_no[o]] = 1'b1;
        e_gnt[w_no[o]] = 1'b1;
        e_vc[w_no[o]] = 1'(w_n1[w_no[o]]);
        e_vcg[w_no[o]*NV + w_n1[w_no[o]]] = 1'b1;
      end
    end
    for (int o = 0; o < NP; o++) begin
      int i;
      i = w_so[o];
      if (i >= 0 && w_no[o] < 0 && !e_nshit[i]) begin
        int k;
        k = i*NV + w_s1[i];
        if (vca_ok[k] && out_rdy[prt(k)*NV + int'(vca_vc[k])]) begin
          e_keep[i] = 1;
          e_sel[o*NP + i] = 1'b1; e_gnt[i] = 1'b1; e_spec[i] = 1'b1;
          e_vc[i] = 1'(w_s1[i]); e_vcg[k] = 1'b1;
        end else e_cancel[i] = 1'b1;
      end
    end
    for (int o = 0; o < NP; o++) e_vld[o] = |e_sel[o*NP +: NP];
  endtask

  task automatic model_adv();
    for (int i = 0; i < NP; i++) begin
      if (e_nshit[i]) n1p[i] = (w_n1[i] + 1) % NV;
      if (e_keep[i])  s1p[i] = (w_s1[i] + 1) % NV;
    end
    for (int o = 0; o < NP; o++) begin
      if (w_no[o] >= 0) n2p[o] = (w_no[o] + 1) % NP;
      else if (w_so[o] >= 0 && e_keep[w_so[o]]) s2p[o] = (w_so[o] + 1) % NP;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // sample mid-cycle against the model, then cross the edge
  task automatic cyc(input string tag);
    #2;
    model_eval();
    chk({tag, " xb_sel"}, 64'(xb_sel), 64'(e_sel));
    chk({tag, " xb_vld/in_gnt/spec/cancel"}, 64'({xb_vld, in_gnt, in_gnt_spec, spec_cancel}),
        64'({e_vld, e_gnt, e_spec, e_cancel}));
    chk({tag, " in_gnt_vc/vc_gnt"}, 64'({in_gnt_vc, vc_gnt}), 64'({e_vc, e_vcg}));
    @(posedge clk);
    model_adv();
    @(negedge clk);
  endtask

  task automatic clr();
    vc_flit = '0; vc_head = '0; vc_owned = '0; vc_port = '0; vc_ovc = '0;
    out_rdy = '0; vca_ok = '0; vca_vc = '0;
  endtask

  task automatic set_ns(input int i, input int v, input int p, input int ov);
    int k;
    k = i*NV + v;
    vc_flit[k] = 1'b1; vc_owned[k] = 1'b1; vc_head[k] = 1'b0;
    vc_port[k*PW +: PW] = PW'(p); vc_ovc[k] = 1'(ov);
    out_rdy[p*NV + ov] = 1'b1;
  endtask

  task automatic set_sp(input int i, input int v, input int p, input int av, input bit ok);
    int k;
    k = i*NV + v;
    vc_flit[k] = 1'b1; vc_owned[k] = 1'b0; vc_head[k] = 1'b1;
    vc_port[k*PW +: PW] = PW'(p); vca_vc[k] = 1'(av); vca_ok[k] = ok;
    out_rdy[p*NV + av] = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R9 got=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin n1p[i] = 0; n2p[i] = 0; s1p[i] = 0; s2p[i] = 0; end
    clr();
    repeat (3) @(negedge clk);
    // R10: reset state with no traffic
    #2 chk("R10 idle", 64'({xb_vld, in_gnt, spec_cancel, vc_gnt}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 and R4: input 0 both VCs, owned, different outputs
    set_ns(0, 0, 1, 0); set_ns(0, 1, 2, 1);
    #2 chk("R10 first pick vc0", 64'(in_gnt_vc[0]), 64'd0);
    cyc("R4 a");
    #2 chk("R4 rotate vc1", 64'(in_gnt_vc[0]), 64'd1);
    cyc("R4 b");
    cyc("R4 c");

    // R1: owned VC whose output VC is off
    clr(); set_ns(3, 1, 4, 1); out_rdy[4*NV + 1] = 1'b0;
    #2 chk("R1 not ready", 64'({xb_vld, vc_gnt}), 64'd0);
    cyc("R1 off");
    out_rdy[4*NV + 1] = 1'b1;
    #2 chk("R1 ready", 64'(vc_gnt[3*NV + 1]), 64'd1);
    cyc("R1 on");

    // R5: three inputs contend for output 3
    clr(); set_ns(0, 0, 3, 0); set_ns(1, 0, 3, 1); set_ns(2, 0, 3, 0);
    for (int n = 0; n < 4; n++) begin
      #2 chk("R5 rotation", 64'(xb_sel[3*NP +: NP]), 64'(5'b1 << (n % 3)));
      cyc("R5");
    end

    // R6: stage-one winner that loses stage two keeps priority
    clr(); set_ns(1, 0, 1, 0); set_ns(0, 1, 2, 0);
    cyc("R6 setup");
    clr(); set_ns(0, 0, 1, 0); set_ns(0, 1, 2, 1); set_ns(2, 0, 1, 1);
    #2 chk("R6 input0 loses", 64'({in_gnt[0], xb_sel[1*NP + 2]}), 64'b01);
    cyc("R6 lose");
    #2 chk("R6 same vc again", 64'({in_gnt[0], in_gnt_vc[0], xb_sel[1*NP + 0]}), 64'b101);
    cyc("R6 win");

    // R2: header without VC is speculative; body without VC is ignored
    clr(); set_sp(3, 1, 4, 0, 1'b1);
    #2 chk("R2 header spec", 64'({in_gnt_spec[3], vc_gnt[7]}), 64'b11);
    cyc("R2 head");
    vc_head[7] = 1'b0;
    #2 chk("R2 body ignored", 64'({xb_vld, vc_gnt, spec_cancel}), 64'd0);
    cyc("R2 body");

    // R7: owned traffic claims the output
    clr(); set_ns(0, 0, 2, 0); set_sp(1, 0, 2, 1, 1'b1);
    #2 chk("R7 owned wins output", 64'({xb_sel[2*NP +: NP], in_gnt[1], spec_cancel[1]}), 64'b0000100);
    cyc("R7");

    // R3: same input has owned and speculative candidates
    clr(); set_ns(0, 0, 1, 0); set_sp(0, 1, 3, 0, 1'b1);
    #2 chk("R3 owned wins input", 64'({in_gnt_spec[0], xb_vld[3], in_gnt[0]}), 64'b001);
    cyc("R3");

    // R8: cancel on failed allocation, then failed readiness, then success
    clr(); set_sp(2, 0, 0, 1, 1'b0); set_sp(2, 1, 0, 0, 1'b0);
    #2 chk("R8 cancel no vc", 64'({spec_cancel[2], xb_vld[0], vc_gnt[5:4]}), 64'b1000);
    cyc("R8 a");
    vca_ok[5:4] = 2'b11; out_rdy[1] = 1'b0; out_rdy[0] = 1'b0;
    #2 chk("R8 cancel not ready", 64'({spec_cancel[2], xb_vld[0]}), 64'b10);
    cyc("R8 b");
    out_rdy[1:0] = 2'b11;
    #2 chk("R8 confirmed", 64'({spec_cancel[2], xb_sel[2], in_gnt_spec[2]}), 64'b011);
    cyc("R8 c");

    // R9: mixed table
    for (int t = 0; t < NT; t++) begin
      vc_flit = T_FLIT[t]; vc_head = T_HEAD[t]; vc_owned = T_OWN[t]; vc_port = T_PORT[t];
      vc_ovc = T_OVC[t]; out_rdy = T_RDY[t]; vca_ok = T_VOK[t]; vca_vc = T_VVC[t];
      cyc("R9 table");
      cyc("R9 table repeat");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule